// File: doc/BRIEF.md
# Port Event Interrupt Status and Enable Unit

This unit collects the event pulses of one storage link port and turns them into a single interrupt request. There are twelve event inputs. Each is a one-cycle pulse, for example command completion, a command error, a PHY ready change or a crossed error-count threshold. Every pulse sets a sticky bit in a raw event field. The unit also shows a masked field, which is the raw field ANDed with a per-event enable. The interrupt output is the OR of the masked field.

Software uses a plain 32-bit register bus with a combinational read path.

- **Status word.** One word carries both views of the events. The masked copy sits in the low bits and the raw copy starts at bit 16. Writing ones to the status word clears events, so writing back a value just read acknowledges exactly the events that value showed.
- **Enable word.** Enables are never written directly. A write to the set address turns bits on, and a write to the clear address turns bits off. A 2-bit steering field in bits 31:30 is updated with the same set/clear rule and is stored next to the enables.

The register offsets are byte addresses on `addr`:

| Offset | Write | Read |
|---|---|---|
| 0x0 | status, write one to clear | status word |
| 0x4 | no effect | zero |
| 0x8 | enable set | enable word |
| 0xC | enable clear | enable word |

Top module: `port_irq_ctrl`

## Requirements
- R1: A pulse on `evt_i[k]` sets raw event bit k at the next clock edge. The bit meanings are: 0 command done, 1 command error, 2 port ready change, 3 power state change, 4 PHY ready change, 5 wake signal received, 6 unrecognised frame, 7 device swapped, 8 symbol decode threshold, 9 CRC threshold, 10 handshake threshold, 11 set-device-bits notify.
- R2: A raw event bit stays set until software clears it, whether or not the event is enabled.
- R3: Reading offset 0x0 returns the raw field in bits 27:16 and raw AND enable in bits 11:0. All other bits read as zero.
- R4: A write to offset 0x0 clears raw bit k when data bit k or data bit 16+k is one. Zero data bits leave events untouched, and writing back a read value clears the events it showed.
- R5: An event pulse in the same cycle as a clearing write to its bit leaves the bit set.
- R6: A write to offset 0x8 sets the enables whose data bits 11:0 are one. Reading offset 0x8 or 0xC returns the enables in bits 11:0, the steering field in bits 31:30 and zero elsewhere.
- R7: A write to offset 0xC clears the enables whose data bits 11:0 are one. Writing 0x0000FFFF there disables every event.
- R8: Data bits 31:30 set the steering bits when written to 0x8 and clear them when written to 0xC. Steering changes neither the status word nor `irq`.
- R9: `irq` is a register equal to the OR of the masked status bits. It changes in the same cycle as the status word it reflects.
- R10: Reset clears every raw event, enable and steering bit, and drives `irq` low.
- R11: A write to offset 0x4 changes no state, and a read of 0x4 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 12 | Single-cycle event pulses |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that:
- a pulse is latched;
- a raw bit only falls after a status write;
- enables and steering move only on their own addresses;
- `irq` tracks the masked raw state.

The bench's scenarios are needed for the rest:
- the exact read word layout;
- the event-wins-over-clear collision;
- acknowledging by writing back a read value;
- the full disable through the clear address.

A constrained random run against a bench model covers the interleavings of events with set, clear and acknowledge writes.

// File: rtl/port_irq_ctrl.sv
module port_irq_ctrl #(
  parameter int NEVT      = 12,
  parameter int RAW_LSB   = 16,
  parameter int STEER_LSB = 30,
  parameter int AW        = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEVT-1:0] evt_i,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  output logic            irq
);
  localparam logic [AW-1:0] A_STAT = AW'(0);
  localparam logic [AW-1:0] A_ESET = AW'(8);
  localparam logic [AW-1:0] A_ECLR = AW'(12);

  logic [NEVT-1:0] raw_q, en_q, raw_d, en_d, clr;
  logic [1:0]      steer_q, steer_d;
  logic            wr_stat, wr_eset, wr_eclr;

  assign wr_stat = wr_en && addr == A_STAT;
  assign wr_eset = wr_en && addr == A_ESET;
  assign wr_eclr = wr_en && addr == A_ECLR;

  assign clr   = wr_stat ? (wdata[NEVT-1:0] | wdata[RAW_LSB +: NEVT]) : '0;
  assign raw_d = (raw_q & ~clr) | evt_i;

  always_comb begin
    en_d    = en_q;
    steer_d = steer_q;
    if (wr_eset) begin
      en_d    = en_q | wdata[NEVT-1:0];
      steer_d = steer_q | wdata[STEER_LSB +: 2];
    end else if (wr_eclr) begin
      en_d    = en_q & ~wdata[NEVT-1:0];
      steer_d = steer_q & ~wdata[STEER_LSB +: 2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q   <= '0;
      en_q    <= '0;
      steer_q <= '0;
      irq     <= 1'b0;
    end else begin
      raw_q   <= raw_d;
      en_q    <= en_d;
      steer_q <= steer_d;
      irq     <= |(raw_d & en_d);
    end
  end

  logic [31:0] stat_word, en_word;
  assign stat_word = (32'(raw_q) << RAW_LSB) | 32'(raw_q & en_q);
  assign en_word   = (32'(steer_q) << STEER_LSB) | 32'(en_q);

  always_comb begin
    case (addr)
      A_STAT:         rdata = stat_word;
      A_ESET, A_ECLR: rdata = en_word;
      default:        rdata = '0;
    endcase
  end
endmodule

// File: rtl/port_irq_ctrl_chk.sv
module port_irq_ctrl_chk #(
  parameter int NEVT = 12,
  parameter int AW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NEVT-1:0] evt_i,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic [31:0]     wdata,
  input logic            irq,
  input logic [NEVT-1:0] raw_q,
  input logic [NEVT-1:0] en_q,
  input logic [1:0]      steer_q
);
  logic stat_wr, en_wr;
  assign stat_wr = wr_en && addr == AW'(0);
  assign en_wr   = wr_en && (addr == AW'(8) || addr == AW'(12));

  AST_EVENT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((raw_q & $past(evt_i)) == $past(evt_i))); // R1

  AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((raw_q & $past(raw_q)) == $past(raw_q))); // R2

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(en_q)); // R6

  AST_STEER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(steer_q)); // R8

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == |(raw_q & en_q))); // R9

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && evt_i == '0) |=>
      ((raw_q & ($past(wdata[NEVT-1:0]) | $past(wdata[16 +: NEVT]))) == '0)); // R4
endmodule

bind port_irq_ctrl port_irq_ctrl_chk #(.NEVT(NEVT), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .irq(irq), .raw_q(raw_q), .en_q(en_q), .steer_q(steer_q)
);

// File: tb/port_irq_ctrl_test.sv
module port_irq_ctrl_test;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [11:0] evt_i = '0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  logic [11:0] m_raw = '0, m_en = '0;
  logic [1:0]  m_steer = '0;

  always #10 clk = ~clk;

  port_irq_ctrl uut (.clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en),
                     .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  function automatic logic [31:0] f_stat(logic [11:0] r, logic [11:0] e);
    return {4'b0, r, 4'b0, r & e};
  endfunction
  function automatic logic [31:0] f_en(logic [1:0] s, logic [11:0] e);
    return {s, 18'b0, e};
  endfunction

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
    addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  // one clock: drive, update model at the edge, then check irq and both views
  task automatic cyc(input logic [11:0] e, input logic we, input logic [3:0] a,
                     input logic [31:0] d, input string tag);
    logic [11:0] clr;
    evt_i = e; wr_en = we; addr = a; wdata = d;
    @(posedge clk);
    clr = (we && a == 4'h0) ? (d[11:0] | d[27:16]) : '0;
    m_raw = (m_raw & ~clr) | e;
    if (we && a == 4'h8) begin m_en |= d[11:0]; m_steer |= d[31:30]; end
    if (we && a == 4'hC) begin m_en &= ~d[11:0]; m_steer &= ~d[31:30]; end
    #2; evt_i = '0; wr_en = 1'b0;
    chk({tag, " R9 irq"}, 32'(irq), 32'(|(m_raw & m_en)));
    rd({tag, " R3 status"}, 4'h0, f_stat(m_raw, m_en));
    rd({tag, " R6 enable"}, 4'h8, f_en(m_steer, m_en));
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #2; rst_n = 1'b1;
    // R10 reset state
    chk("R10 irq after reset", 32'(irq), 32'h0);
    rd("R10 status after reset", 4'h0, 32'h0);
    rd("R10 enable after reset", 4'hC, 32'h0);
    // R1 R2 each event latches while disabled
    for (int k = 0; k < 12; k++) cyc(12'(1) << k, 1'b0, 4'h0, 0, "R1 R2 single event");
    rd("R1 all raw set", 4'h0, 32'h0FFF_0000);
    // R4 partial clear through masked field, then write-back acknowledge
    cyc(0, 1'b1, 4'h0, 32'h0000_000F, "R4 clear low");
    rd("R4 after low clear", 4'h0, 32'h0FF0_0000);
    cyc(0, 1'b1, 4'h0, 32'h0FF0_0000, "R4 write back");
    rd("R4 all clear", 4'h0, 32'h0);
    // R6 typical enable set, R9 irq
    cyc(0, 1'b1, 4'h8, 32'h0000_0093, "R6 set default enables");
    cyc(12'h004, 1'b0, 4'h0, 0, "R9 disabled event");
    chk("R9 disabled event no irq", 32'(irq), 32'h0);
    cyc(12'h080, 1'b0, 4'h0, 0, "R9 enabled event");
    chk("R9 enabled event irq", 32'(irq), 32'h1);
    // R5 collision: event bit 7 and clear of bit 7 in same cycle
    cyc(12'h080, 1'b1, 4'h0, 32'h0084_0000, "R5 collision");
    rd("R5 bit stays set", 4'h0, 32'h0080_0080);
    // R8 steering
    cyc(0, 1'b1, 4'h8, 32'hC000_0000, "R8 steer set");
    rd("R8 status unaffected", 4'h0, 32'h0080_0080);
    cyc(0, 1'b1, 4'hC, 32'h4000_0000, "R8 steer clear");
    rd("R8 steer value", 4'hC, 32'h8000_0093);
    // R11 reserved offset
    cyc(0, 1'b1, 4'h4, 32'hFFFF_FFFF, "R11 reserved write");
    rd("R11 reserved read", 4'h4, 32'h0);
    // R7 full disable
    cyc(0, 1'b1, 4'hC, 32'h0000_FFFF, "R7 disable all");
    rd("R7 enables zero", 4'h8, 32'h8000_0000);
    chk("R7 irq low", 32'(irq), 32'h0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [11:0] e;
      e = ($urandom % 3 == 0) ? 12'($urandom) : 12'h0;
      case ($urandom % 6)
        0: cyc(e, 1'b1, 4'h0, $urandom, "R4 rand clear");
        1: begin v = f_stat(m_raw, m_en); cyc(e, 1'b1, 4'h0, v, "R4 rand ack"); end
        2: cyc(e, 1'b1, 4'h8, $urandom, "R6 rand set");
        3: cyc(e, 1'b1, 4'hC, $urandom, "R7 rand clear");
        4: cyc(e, 1'b1, 4'h4, $urandom, "R11 rand reserved");
        default: cyc(e, 1'b0, 4'h0, 0, "R1 rand idle");
      endcase
    end
    // R10 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #2; rst_n = 1'b1;
    chk("R10 irq after late reset", 32'(irq), 32'h0);
    rd("R10 status after late reset", 4'h0, 32'h0);
    rd("R10 enable after late reset", 4'h8, 32'h0);
    report();
  end
endmodule